// File: doc/BRIEF.md
# Touch Panel Report Decoder

This block sits behind a serial byte receiver attached to a resistive touch controller. It gathers the controller's five-byte reports and turns each complete report into a single-cycle event. The event carries the pen state, the 10-bit X and Y positions, and the character cell under the pen on a 40-column by 30-row text screen. A display controller can use the cell to place a cursor or select a menu item.

Each report starts with a command byte that gives the pen state. Four coordinate bytes follow it. The decoder checks the fixed zero bits in every coordinate byte. A command byte always starts a new report, so the decoder recovers by itself from lost or corrupted bytes. Each pen-down event also starts a beep enable pulse of fixed length, which confirms the touch audibly.

Top module: `touch_pkt_dec`

## Requirements
- R1: While reset is asserted and after it is released, `evt_valid` and `beep_en` are low until a complete report arrives.
- R2: A report is five accepted bytes: a command byte, X high, X low, Y high, Y low. When the fifth byte is accepted, `evt_valid` is high for exactly one cycle, in the cycle after that byte is sampled. In that cycle `evt_x` = {X high[2:0], X low[6:0]} and `evt_y` = {Y high[2:0], Y low[6:0]}.
- R3: Command 0xFF reports pen down and gives `evt_pen_down` = 1. Command 0xBF reports pen up and gives `evt_pen_down` = 0.
- R4: Non-command bytes that arrive while no report is open are ignored and produce no event.
- R5: A high byte with any of bits 7..3 set, or a low byte with bit 7 set, discards the open report without an event. The decoder then ignores bytes until the next command byte.
- R6: A command byte (0xFF or 0xBF) received partway through a report drops the partial report and starts a new one. The pen state of the new report comes from that command byte.
- R7: While `evt_valid` is high, `evt_col` = floor(`evt_x`·40/1024) and `evt_row` = floor(`evt_y`·30/1024). These values always lie in 0..39 and 0..29.
- R8: `beep_en` rises in the same cycle as a pen-down event and stays high for exactly BEEP_CYCLES cycles. A further pen-down event during the pulse restarts the full length. Pen-up events do not start a beep.
- R9: Cycles in which `rx_valid` is low do not advance or alter report assembly. Bytes may arrive with any number of idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | `rx_byte` holds a new byte this cycle |
| rx_byte | input | 8 | Received byte |
| evt_valid | output | 1 | One-cycle pulse for a complete report |
| evt_pen_down | output | 1 | 1 = pen down, 0 = pen up |
| evt_x | output | 10 | X coordinate |
| evt_y | output | 10 | Y coordinate |
| evt_col | output | 6 | Character column 0..39 |
| evt_row | output | 5 | Character row 0..29 |
| beep_en | output | 1 | Confirmation beep enable |

## Verification
The assertions assume that `rx_valid` is a clean one-cycle qualifier on each byte and carries no X values after reset. They also assume that a report needs at least five accepted bytes, so two events can never fall in adjacent cycles. The stimulus drives each byte on the falling edge, either back to back or with idle gaps. Well-formed reports are mixed with stray bytes, bytes that break the zero-bit rules, and command bytes injected partway through a report. Every report the bench expects to succeed goes into a scoreboard queue. Any event that appears without a queued entry is counted as a failure.

// File: rtl/touch_pkg.sv
package touch_pkg;
  localparam logic [7:0] CMD_PEN_DOWN = 8'hFF;
  localparam logic [7:0] CMD_PEN_UP   = 8'hBF;

  typedef enum logic [2:0] {
    S_HUNT, S_XH, S_XL, S_YH, S_YL
  } asm_state_t;

  // Maps a coordinate of cw bits onto a grid of 'cells' cells.
  function automatic int unsigned scale_cell(int unsigned coord,
                                             int unsigned cells,
                                             int unsigned cw);
    return (coord * cells) >> cw;
  endfunction

  function automatic logic is_command(logic [7:0] b);
    return (b == CMD_PEN_DOWN) || (b == CMD_PEN_UP);
  endfunction
endpackage

// File: rtl/touch_frame_asm.sv
module touch_frame_asm
  import touch_pkg::*;
#(
  parameter int HI_BITS = 3,
  parameter int LO_BITS = 7,
  localparam int COORD_W = HI_BITS + LO_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_valid,
  input  logic [7:0]         byte_in,
  output logic               evt_valid,
  output logic               evt_pen,
  output logic [COORD_W-1:0] evt_x,
  output logic [COORD_W-1:0] evt_y,
  output logic               fire_pen_down
);
  asm_state_t         state;
  logic               pen_q;
  logic [HI_BITS-1:0] hi_q;
  logic [COORD_W-1:0] x_q;

  // Named events for the checks
  logic cmd_seen, hi_ok, lo_ok, in_data, data_ok, bad_fmt, fire;

  assign cmd_seen = byte_valid && is_command(byte_in);
  assign hi_ok    = (byte_in[7:HI_BITS] == '0);
  assign lo_ok    = (byte_in[7:LO_BITS] == '0);
  assign in_data  = (state != S_HUNT);
  assign data_ok  = (state == S_XH || state == S_YH) ? hi_ok : lo_ok;
  assign bad_fmt  = byte_valid && !cmd_seen && in_data && !data_ok;
  assign fire     = byte_valid && !cmd_seen && (state == S_YL) && lo_ok;
  assign fire_pen_down = fire && pen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_HUNT;
      pen_q     <= 1'b0;
      hi_q      <= '0;
      x_q       <= '0;
      evt_valid <= 1'b0;
      evt_pen   <= 1'b0;
      evt_x     <= '0;
      evt_y     <= '0;
    end else begin
      evt_valid <= 1'b0;
      if (cmd_seen) begin
        state <= S_XH;
        pen_q <= (byte_in == CMD_PEN_DOWN);
      end else if (byte_valid && in_data) begin
        if (!data_ok) begin
          state <= S_HUNT;
        end else begin
          case (state)
            S_XH: begin hi_q <= byte_in[HI_BITS-1:0]; state <= S_XL; end
            S_XL: begin x_q <= {hi_q, byte_in[LO_BITS-1:0]}; state <= S_YH; end
            S_YH: begin hi_q <= byte_in[HI_BITS-1:0]; state <= S_YL; end
            default: begin
              evt_x     <= x_q;
              evt_y     <= {hi_q, byte_in[LO_BITS-1:0]};
              evt_pen   <= pen_q;
              evt_valid <= 1'b1;
              state     <= S_HUNT;
            end
          endcase
        end
      end
    end
  end

  p_cmd_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_seen |=> (state == S_XH));
  p_bad_to_hunt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fmt |=> (state == S_HUNT) && !evt_valid);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> $stable(state) && $stable(x_q));
  p_evt_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);
endmodule

// File: rtl/touch_cell_map.sv
module touch_cell_map
  import touch_pkg::*;
#(
  parameter int COORD_W = 10,
  parameter int COLS = 40,
  parameter int ROWS = 30,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic [COL_W-1:0]   col_o,
  output logic [ROW_W-1:0]   row_o
);
  assign col_o = COL_W'(scale_cell(int'(x_i), COLS, COORD_W));
  assign row_o = ROW_W'(scale_cell(int'(y_i), ROWS, COORD_W));
endmodule

// File: rtl/touch_beep_timer.sv
module touch_beep_timer #(
  parameter int BEEP_CYCLES = 100,
  localparam int CNT_W = $clog2(BEEP_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic beep_en
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (trigger)      cnt <= CNT_W'(BEEP_CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign beep_en = (cnt != '0);

  p_beep_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (cnt == CNT_W'(BEEP_CYCLES)));
endmodule

// File: rtl/touch_pkt_dec.sv
module touch_pkt_dec #(
  parameter int HI_BITS = 3,
  parameter int LO_BITS = 7,
  parameter int COLS = 40,
  parameter int ROWS = 30,
  parameter int BEEP_CYCLES = 100,
  localparam int COORD_W = HI_BITS + LO_BITS,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  output logic               evt_valid,
  output logic               evt_pen_down,
  output logic [COORD_W-1:0] evt_x,
  output logic [COORD_W-1:0] evt_y,
  output logic [COL_W-1:0]   evt_col,
  output logic [ROW_W-1:0]   evt_row,
  output logic               beep_en
);
  logic fire_pd;

  touch_frame_asm #(.HI_BITS(HI_BITS), .LO_BITS(LO_BITS)) u_asm (
    .clk(clk), .rst_n(rst_n), .byte_valid(rx_valid), .byte_in(rx_byte),
    .evt_valid(evt_valid), .evt_pen(evt_pen_down), .evt_x(evt_x),
    .evt_y(evt_y), .fire_pen_down(fire_pd)
  );

  touch_cell_map #(.COORD_W(COORD_W), .COLS(COLS), .ROWS(ROWS)) u_map (
    .x_i(evt_x), .y_i(evt_y), .col_o(evt_col), .row_o(evt_row)
  );

  touch_beep_timer #(.BEEP_CYCLES(BEEP_CYCLES)) u_beep (
    .clk(clk), .rst_n(rst_n), .trigger(fire_pd), .beep_en(beep_en)
  );

  p_cell_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_col < COL_W'(COLS)) && (evt_row < ROW_W'(ROWS)));
  p_beep_with_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_pen_down) |-> beep_en);
  p_beep_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beep_en) |-> (evt_valid && evt_pen_down));
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !evt_valid && !beep_en);
endmodule

// File: tb/touch_pkt_dec_tb.sv
module touch_pkt_dec_tb;
  localparam int NBEEP = 20;

  typedef struct {
    logic       pd;
    logic [9:0] x, y;
    logic [5:0] col;
    logic [4:0] row;
  } exp_t;

  logic clk = 0, rst_n = 0, rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic evt_valid, evt_pen_down, beep_en;
  logic [9:0] evt_x, evt_y;
  logic [5:0] evt_col;
  logic [4:0] evt_row;

  int checks = 0, errors = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  touch_pkt_dec #(.BEEP_CYCLES(NBEEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .evt_valid(evt_valid), .evt_pen_down(evt_pen_down), .evt_x(evt_x),
    .evt_y(evt_y), .evt_col(evt_col), .evt_row(evt_row), .beep_en(beep_en)
  );

  task automatic check(string req, bit ok, string got, string want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %s expected %s", req, got, want);
    end
  endtask

  // Expected report from the requirements (R2, R3, R7)
  function automatic exp_t model(logic [7:0] cmd, logic [7:0] xh, logic [7:0] xl,
                                 logic [7:0] yh, logic [7:0] yl);
    exp_t e;
    int xi, yi;
    xi = int'(xh) * 128 + int'(xl);
    yi = int'(yh) * 128 + int'(yl);
    e.pd  = (cmd == 8'hFF);
    e.x   = 10'(xi);
    e.y   = 10'(yi);
    e.col = 6'(xi * 40 / 1024);
    e.row = 5'(yi * 30 / 1024);
    return e;
  endfunction

  task automatic send_byte(logic [7:0] b, int gap);
    @(negedge clk);
    rx_valid = 1;
    rx_byte  = b;
    if (gap > 0) begin
      @(negedge clk);
      rx_valid = 0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic send_report(logic [7:0] cmd, logic [7:0] xh, logic [7:0] xl,
                             logic [7:0] yh, logic [7:0] yl, int gap, bit expect_evt);
    if (expect_evt) sb.push_back(model(cmd, xh, xl, yh, yl));
    send_byte(cmd, gap);
    send_byte(xh, gap);
    send_byte(xl, gap);
    send_byte(yh, gap);
    send_byte(yl, gap);
    if (gap == 0) idle();
  endtask

  // Monitor: compares every event against the scoreboard
  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      if (sb.size() == 0) begin
        check("R4/R5 unexpected event", 0,
              $sformatf("x=%0d y=%0d", evt_x, evt_y), "no event");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check("R2/R3/R7 event fields",
              evt_pen_down == e.pd && evt_x == e.x && evt_y == e.y &&
              evt_col == e.col && evt_row == e.row,
              $sformatf("pd=%0d x=%0d y=%0d col=%0d row=%0d",
                        evt_pen_down, evt_x, evt_y, evt_col, evt_row),
              $sformatf("pd=%0d x=%0d y=%0d col=%0d row=%0d",
                        e.pd, e.x, e.y, e.col, e.row));
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int run;
    repeat (3) @(negedge clk);
    // R1: quiet during and after reset
    check("R1 reset", !evt_valid && !beep_en,
          $sformatf("%0d%0d", evt_valid, beep_en), "00");
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 after reset", !evt_valid && !beep_en,
          $sformatf("%0d%0d", evt_valid, beep_en), "00");

    // R2 R3 R7: full-scale pen down, then beep length (R8)
    send_report(8'hFF, 8'h07, 8'h7F, 8'h07, 8'h7F, 0, 1);
    run = 0;
    while (beep_en && run < 200) begin run++; @(negedge clk); end
    check("R8 beep length", run == NBEEP, $sformatf("%0d", run), $sformatf("%0d", NBEEP));

    // R3: pen up at origin; R8 no beep on pen up
    send_report(8'hBF, 8'h00, 8'h00, 8'h00, 8'h00, 0, 1);
    run = 0;
    repeat (5) begin if (beep_en) run++; @(negedge clk); end
    check("R8 pen-up silent", run == 0, $sformatf("%0d", run), "0");

    // R7 boundaries: x=25/26, y=34/35, and mid scale
    send_report(8'hFF, 8'h00, 8'h19, 8'h00, 8'h22, 0, 1);
    send_report(8'hFF, 8'h00, 8'h1A, 8'h00, 8'h23, 0, 1);
    send_report(8'hBF, 8'h04, 8'h00, 8'h04, 8'h00, 0, 1);
    send_report(8'hBF, 8'h02, 8'h55, 8'h05, 8'h2A, 0, 1);

    // R9: idle gaps between bytes
    send_report(8'hFF, 8'h03, 8'h11, 8'h06, 8'h44, 3, 1);
    send_report(8'hBF, 8'h01, 8'h7E, 8'h02, 8'h01, 1, 1);

    // R4: stray data bytes before a command
    send_byte(8'h12, 0); send_byte(8'h05, 0); send_byte(8'h7F, 0); idle();
    send_report(8'hFF, 8'h05, 8'h0A, 8'h01, 8'h33, 0, 1);

    // R5: bad high byte, then trailing data must be ignored
    send_byte(8'hFF, 0); send_byte(8'h08, 0);
    send_byte(8'h01, 0); send_byte(8'h02, 0); send_byte(8'h03, 0); idle();
    // R5: bad low byte in Y low position
    send_report(8'hBF, 8'h01, 8'h01, 8'h01, 8'h80, 0, 0);
    // R5: bad X low byte
    send_report(8'hFF, 8'h01, 8'hC0, 8'h01, 8'h01, 0, 0);
    repeat (3) @(negedge clk);
    check("R5 no queued leftovers", sb.size() == 0, $sformatf("%0d", sb.size()), "0");
    send_report(8'hBF, 8'h06, 8'h06, 8'h03, 8'h03, 0, 1);

    // R6: restart on command byte partway through
    sb.push_back(model(8'hBF, 8'h02, 8'h10, 8'h07, 8'h70));
    send_byte(8'hFF, 0); send_byte(8'h01, 0); send_byte(8'h02, 0);
    send_byte(8'hBF, 0); send_byte(8'h02, 0); send_byte(8'h10, 0);
    send_byte(8'h07, 0); send_byte(8'h70, 0); idle();

    // R8: second pen down during pulse restarts full length
    repeat (NBEEP + 2) @(negedge clk);
    send_report(8'hFF, 8'h01, 8'h00, 8'h01, 8'h00, 0, 1);
    send_report(8'hFF, 8'h02, 8'h00, 8'h02, 8'h00, 0, 1);
    run = 0;
    while (beep_en && run < 200) begin run++; @(negedge clk); end
    check("R8 beep restart", run == NBEEP, $sformatf("%0d", run), $sformatf("%0d", NBEEP));

    repeat (4) @(negedge clk);
    check("R2 all events seen", sb.size() == 0, $sformatf("%0d", sb.size()), "0");
    finish_run();
  end
endmodule